// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block turns a 32-bit system-bus address into one of eight chip selects for an external memory bus. Software programs one decode word per bank through a small register port. Each word packs an enable flag, a base address and an inverted "don't care" mask, all at 128 KiB granularity. The decode runs every cycle, purely combinationally, and the block drives a one-hot chip-select vector together with a hit flag.

A boot-swap strap is captured while reset is held low. When it is set, the physical chip selects 0 and 1 trade places, so the decode word of bank 0 steers chip select 1 and the word of bank 1 steers chip select 0. The block also reproduces a hardware quirk. If the decode word of bank 0 or bank 1 is entirely zero, every access lands on the boot chip select, whatever the enable bits say. Five timing-parameter registers are held for software but do not touch the decode.

The register port has a two-state machine. In `PORT_IDLE` it accepts requests (ready high). A write completes in place and the machine stays in `PORT_IDLE`. A read moves it `PORT_IDLE -> PORT_READ`, and in that cycle the read data is valid and ready is low. `PORT_READ -> PORT_IDLE` follows unconditionally on the next clock.

Top module: `csd_decoder`

## Requirements
- R1: Decode word layout: bit 0 is enable, bits 31:17 hold the base, and bits 15:1 are a care mask in which bit k+1 governs address bit k+17. An enabled bank matches when every address bit from 31 to 17 whose care bit is 1 equals the base bit.
- R2: Address bits 16:0 never affect the decode.
- R3: A bank whose enable bit is 0 never matches, even when its base and mask fields are non-zero.
- R4: When several banks match, the lowest-numbered bank wins. The chip-select vector is at most one-hot, and hit is 1 exactly when a chip select is high. With no match, cs is 0 and hit is 0.
- R5: If the bank 0 or the bank 1 word equals zero, every address drives chip select 0 (chip select 1 when swapped) with hit 1, and banks 2 to 7 cannot be reached.
- R6: The boot-swap strap is sampled only while rst_n is low. When it is sampled as 1, bank word 0 drives chip select 1 and bank word 1 drives chip select 0. Changing the strap after reset has no effect.
- R7: After reset, the bank 0 word reads 0x00000001 when the strap was 0 and 0x00000000 when it was 1. All other bank words and timing registers read 0.
- R8: Bank word i sits at register offset 0x100 + 0x10*i and reads back the value written. A read accepted in PORT_IDLE gives rvalid=1, ready=0 and the data on the next cycle (PORT_READ).
- R9: Timing registers at offsets 0x200, 0x204, 0x208, 0x20C and 0x300 read back their written values and have no effect on cs or hit.
- R10: A write is accepted at a clock edge while ready is 1, and the decode reflects the new word immediately after that edge, not before it.
- R11: Writes to unmapped offsets (for example 0x104, 0x180 or 0x210) change nothing, and reads from them return 0.
- R12: A word of all ones confines its bank to addresses 0xFFFE0000 to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap_i | input | 1 | Strap that exchanges chip selects 0 and 1; sampled during reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_ready_o | output | 1 | Port can accept a request (PORT_IDLE) |
| reg_rvalid_o | output | 1 | Read data valid (PORT_READ) |
| reg_rdata_o | output | 32 | Read data |
| bus_addr_i | input | 32 | System-bus address to decode |
| cs_o | output | 8 | One-hot chip selects |
| hit_o | output | 1 | Some chip select is active |

## Verification
On every cycle, the embedded properties check that the chip-select vector is at most one-hot and agrees with hit. They also check that a zero word in bank 0 or 1 forces the boot chip select, that a disabled upper bank never drives its chip select, that a latched strap holds steady, and that the read handshake and bank 0 write land as specified. Only the bench's scenarios can show the arithmetic of the decode: the base and mask comparison, priority among overlapping banks, the parked all-ones window, the swap of physical outputs, and the fact that timing and unmapped writes leave the decode alone. The bench shows these by comparing cs and hit against a behavioural model on every clock, alongside directed reads and decodes.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

    localparam int WORD_W     = 32;
    localparam int GRAN_LSB   = 17;
    localparam int FIELD_W    = WORD_W - GRAN_LSB;
    localparam int EN_BIT     = 0;
    localparam int MASK_LSB   = 1;
    localparam int NUM_TIMING = 5;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_READ = 1'b1
    } port_state_e;

    // Byte offset of timing-parameter register j: four consecutive words, then one at 0x300.
    function automatic int timing_offset(input int j);
        if (j < 4) return 'h200 + 4 * j;
        return 'h300;
    endfunction

endpackage

// File: rtl/csd_regs.sv
`timescale 1ns/1ps
module csd_regs
    import csd_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int REG_AW      = 12,
    parameter int BANK_BASE   = 'h100,
    parameter int BANK_STRIDE = 'h10
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               boot_swap_i,
    input  logic                               reg_req_i,
    input  logic                               reg_we_i,
    input  logic [REG_AW-1:0]                  reg_addr_i,
    input  logic [WORD_W-1:0]                  reg_wdata_i,
    output logic                               reg_ready_o,
    output logic                               reg_rvalid_o,
    output logic [WORD_W-1:0]                  reg_rdata_o,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   bank_words_o,
    output logic                               swap_o
);

    port_state_e state_q, state_d;

    logic                  wr_en;
    logic                  rd_en;
    logic [NUM_BANKS-1:0]  bank_sel;
    logic [NUM_TIMING-1:0] tim_sel;
    logic [WORD_W-1:0]     bank_q [NUM_BANKS];
    logic [WORD_W-1:0]     tim_q  [NUM_TIMING];
    logic [WORD_W-1:0]     rd_mux;
    logic [WORD_W-1:0]     rdata_q;
    logic                  swap_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (reg_req_i && !reg_we_i) state_d = PORT_READ;
            PORT_READ: state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        reg_ready_o  = 1'b0;
        reg_rvalid_o = 1'b0;
        unique case (state_q)
            PORT_IDLE: reg_ready_o  = 1'b1;
            PORT_READ: reg_rvalid_o = 1'b1;
            default:   reg_ready_o  = 1'b0;
        endcase
    end

    assign wr_en = reg_req_i &  reg_we_i & reg_ready_o;
    assign rd_en = reg_req_i & ~reg_we_i & reg_ready_o;

    // Strap capture: follows the strap only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) swap_q <= boot_swap_i;
    end
    assign swap_o = swap_q;

    // Bank decode words
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic [WORD_W-1:0] rst_val;
        assign bank_sel[i] = (reg_addr_i == REG_AW'(BANK_BASE + i * BANK_STRIDE));
        if (i == 0) begin : g_boot
            assign rst_val = {{(WORD_W-1){1'b0}}, ~boot_swap_i};
        end else begin : g_plain
            assign rst_val = '0;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)                    bank_q[i] <= rst_val;
            else if (wr_en && bank_sel[i]) bank_q[i] <= reg_wdata_i;
        end
        assign bank_words_o[i] = bank_q[i];
    end

    // Timing-parameter storage
    for (genvar j = 0; j < NUM_TIMING; j++) begin : g_tim
        assign tim_sel[j] = (reg_addr_i == REG_AW'(timing_offset(j)));
        always_ff @(posedge clk) begin
            if (!rst_n)                   tim_q[j] <= '0;
            else if (wr_en && tim_sel[j]) tim_q[j] <= reg_wdata_i;
        end
    end

    // Read multiplexer: unmapped offsets give zero
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (bank_sel[i]) rd_mux = rd_mux | bank_q[i];
        for (int j = 0; j < NUM_TIMING; j++)
            if (tim_sel[j]) rd_mux = rd_mux | tim_q[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end
    assign reg_rdata_o = rdata_q;

    // R8
    read_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ready_o && reg_req_i && !reg_we_i) |=> (reg_rvalid_o && !reg_ready_o));

    // R10
    bank0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel[0]) |=> (bank_q[0] == $past(reg_wdata_i)));

    // R6
    swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(swap_q));

endmodule

// File: rtl/csd_bank_match.sv
`timescale 1ns/1ps
module csd_bank_match
    import csd_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] words_i,
    input  logic [WORD_W-1:0]                bus_addr_i,
    output logic [NUM_BANKS-1:0]             match_o
);

    logic [NUM_BANKS-1:0] unused_pad;
    logic [GRAN_LSB-1:0]  unused_low;

    assign unused_low = bus_addr_i[GRAN_LSB-1:0];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
        logic [FIELD_W-1:0] diff;
        logic [FIELD_W-1:0] care;
        assign diff          = bus_addr_i[WORD_W-1:GRAN_LSB] ^ words_i[i][WORD_W-1:GRAN_LSB];
        assign care          = words_i[i][MASK_LSB +: FIELD_W];
        assign match_o[i]    = words_i[i][EN_BIT] && ((diff & care) == '0);
        assign unused_pad[i] = words_i[i][GRAN_LSB-1];
    end

endmodule

// File: rtl/csd_cs_select.sv
`timescale 1ns/1ps
module csd_cs_select
    import csd_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [NUM_BANKS-1:0] match_i,
    input  logic [WORD_W-1:0]    word0_i,
    input  logic [WORD_W-1:0]    word1_i,
    input  logic                 swap_i,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic                 hit_o
);

    localparam int IDX_W = $clog2(NUM_BANKS);

    logic             catch_all;
    logic             found;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] phys;

    assign catch_all = (word0_i == '0) || (word1_i == '0);

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (!found && match_i[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
        phys = win;
        if (win < IDX_W'(2)) phys = win ^ IDX_W'(swap_i);
        cs_o = '0;
        if (catch_all)  cs_o[IDX_W'(swap_i)] = 1'b1;
        else if (found) cs_o[phys] = 1'b1;
        hit_o = catch_all | found;
    end

endmodule

// File: rtl/csd_decoder.sv
`timescale 1ns/1ps
module csd_decoder
    import csd_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int REG_AW      = 12,
    parameter int BANK_BASE   = 'h100,
    parameter int BANK_STRIDE = 'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_swap_i,
    input  logic                 reg_req_i,
    input  logic                 reg_we_i,
    input  logic [REG_AW-1:0]    reg_addr_i,
    input  logic [WORD_W-1:0]    reg_wdata_i,
    output logic                 reg_ready_o,
    output logic                 reg_rvalid_o,
    output logic [WORD_W-1:0]    reg_rdata_o,
    input  logic [WORD_W-1:0]    bus_addr_i,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic                 hit_o
);

    logic [NUM_BANKS-1:0][WORD_W-1:0] words;
    logic [NUM_BANKS-1:0]             match;
    logic                             swap;

    csd_regs #(
        .NUM_BANKS   (NUM_BANKS),
        .REG_AW      (REG_AW),
        .BANK_BASE   (BANK_BASE),
        .BANK_STRIDE (BANK_STRIDE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_swap_i  (boot_swap_i),
        .reg_req_i    (reg_req_i),
        .reg_we_i     (reg_we_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_ready_o  (reg_ready_o),
        .reg_rvalid_o (reg_rvalid_o),
        .reg_rdata_o  (reg_rdata_o),
        .bank_words_o (words),
        .swap_o       (swap)
    );

    csd_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
        .words_i    (words),
        .bus_addr_i (bus_addr_i),
        .match_o    (match)
    );

    csd_cs_select #(.NUM_BANKS(NUM_BANKS)) u_sel (
        .match_i (match),
        .word0_i (words[0]),
        .word1_i (words[1]),
        .swap_i  (swap),
        .cs_o    (cs_o),
        .hit_o   (hit_o)
    );

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o) && (hit_o == (cs_o != '0)));

    // R5
    catch_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((words[0] == '0) || (words[1] == '0)) |-> (hit_o && cs_o[swap]));

    for (genvar g = 2; g < NUM_BANKS; g++) begin : g_dis_chk
        // R3
        bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!words[g][EN_BIT] && (words[0] != '0) && (words[1] != '0)) |-> !cs_o[g]);
    end

endmodule

// File: tb/csd_decoder_bench.sv
`timescale 1ns/1ps
module csd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] bus = '0;
    logic        ready, rvalid, hit;
    logic [31:0] rdata;
    logic [7:0]  cs;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;

    logic [31:0] m_word [8];
    logic [31:0] m_tim  [5];
    logic        m_swap;

    always #4 clk = ~clk;

    csd_decoder u_csd_decoder (
        .clk(clk), .rst_n(rst_n), .boot_swap_i(strap),
        .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_ready_o(ready), .reg_rvalid_o(rvalid), .reg_rdata_o(rdata),
        .bus_addr_i(bus), .cs_o(cs), .hit_o(hit)
    );

    // Behavioural reference: returns {hit, cs}
    function automatic logic [8:0] model_dec(input logic [31:0] a);
        int w;
        logic [7:0] c;
        bit ok;
        w = -1;
        c = '0;
        if (m_word[0] == 0 || m_word[1] == 0) begin
            c[m_swap] = 1'b1;
            return {1'b1, c};
        end
        for (int i = 0; i < 8; i++) begin
            if (w < 0 && m_word[i][0]) begin
                ok = 1'b1;
                for (int b = 17; b < 32; b++)
                    if (m_word[i][b-16] && (a[b] != m_word[i][b])) ok = 1'b0;
                if (ok) w = i;
            end
        end
        if (w < 0) return 9'h000;
        if (w < 2 && m_swap) w = 1 - w;
        c[w] = 1'b1;
        return {1'b1, c};
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        for (int i = 0; i < 8; i++) if (a == 12'(32'h100 + 16 * i)) m_word[i] = d;
        for (int j = 0; j < 4; j++) if (a == 12'(32'h200 + 4 * j)) m_tim[j] = d;
        if (a == 12'h300) m_tim[4] = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [8:0] e;
        if (cmp_en && rst_n) begin
            e = model_dec(bus);
            n_cmp++;
            if ({hit, cs} !== e) begin
                n_bad++;
                $display("FAIL R4 per-cycle decode addr=%h actual=%h expected=%h", bus, {hit, cs}, e);
            end
        end
    end

    task automatic do_reset(input logic s);
        @(posedge clk); #1;
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) m_word[i] = '0;
        for (int j = 0; j < 5; j++) m_tim[j] = '0;
        m_word[0] = {31'b0, ~s};
        m_swap = s;
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk); #1;
        req = 1'b0;
        chk("R8 rvalid in PORT_READ", {31'b0, rvalid}, 32'd1);
        chk("R8 ready low in PORT_READ", {31'b0, ready}, 32'd0);
        chk(tag, rdata, exp);
    endtask

    task automatic dec(input logic [31:0] a, input logic [8:0] exp, input string tag);
        @(posedge clk); #1;
        bus = a;
        #2;
        chk(tag, {23'b0, hit, cs}, {23'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        cmp_en = 1'b1;
        chk("R8 ready after reset", {31'b0, ready}, 32'd1);
        dec(32'h5000_0000, 9'h101, "R5 zero bank1 word catches all");
        rd(12'h100, 32'h0000_0001, "R7 bank0 reset word no swap");
        rd(12'h130, 32'h0, "R7 bank3 reset word");
        rd(12'h200, 32'h0, "R7 timing reset value");

        wr(12'h110, 32'hFFFF_FFFF);
        rd(12'h110, 32'hFFFF_FFFF, "R8 bank1 readback");
        dec(32'h4000_0000, 9'h101, "R1 bank0 match-all word");
        dec(32'hFFFE_0000, 9'h101, "R4 lowest bank wins");

        wr(12'h100, 32'hFFFF_FFFF);
        dec(32'hFFFF_FFFF, 9'h101, "R12 parked bank top window");
        dec(32'hFFFC_0000, 9'h000, "R12 parked bank below top window");

        wr(12'h120, 32'h0800_FE01);
        dec(32'h0900_1234, 9'h104, "R1 bank2 inside");
        dec(32'h0A00_0000, 9'h000, "R1 bank2 outside");
        dec(32'h0800_0000, 9'h104, "R2 low bits zero");
        dec(32'h0801_FFFF, 9'h104, "R2 low bits ones");

        wr(12'h130, 32'h0800_FC01);
        dec(32'h0900_0000, 9'h104, "R4 overlap bank2 wins");
        dec(32'h0A00_0000, 9'h108, "R1 bank3 only");

        wr(12'h130, 32'h0800_FC00);
        dec(32'h0A00_0000, 9'h000, "R3 disabled bank3");
        rd(12'h130, 32'h0800_FC00, "R8 bank3 readback");

        // R10: write timing around the accepting edge
        @(posedge clk); #1;
        req = 1'b1; we = 1'b1; addr = 12'h130; wdata = 32'h0800_FC01;
        #2;
        chk("R10 before accepting edge", {23'b0, hit, cs}, 32'h000);
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
        model_write(12'h130, 32'h0800_FC01);
        chk("R10 after accepting edge", {23'b0, hit, cs}, 32'h108);

        wr(12'h200, 32'h1111_0001);
        wr(12'h204, 32'h2222_0002);
        wr(12'h208, 32'h3333_0003);
        wr(12'h20C, 32'h4444_0004);
        wr(12'h300, 32'h5555_0005);
        rd(12'h200, 32'h1111_0001, "R9 timing 0x200");
        rd(12'h204, 32'h2222_0002, "R9 timing 0x204");
        rd(12'h208, 32'h3333_0003, "R9 timing 0x208");
        rd(12'h20C, 32'h4444_0004, "R9 timing 0x20C");
        rd(12'h300, 32'h5555_0005, "R9 timing 0x300");
        dec(32'h0A00_0000, 9'h108, "R9 decode unchanged bank3");
        dec(32'h0900_0000, 9'h104, "R9 decode unchanged bank2");

        wr(12'h104, 32'h0);
        wr(12'h180, 32'h0);
        wr(12'h210, 32'h0);
        dec(32'h5000_0000, 9'h000, "R11 unmapped writes ignored");
        rd(12'h104, 32'h0, "R11 read 0x104");
        rd(12'h180, 32'h0, "R11 read 0x180");
        rd(12'h210, 32'h0, "R11 read 0x210");
        rd(12'h100, 32'hFFFF_FFFF, "R11 bank0 untouched");

        wr(12'h110, 32'h0);
        dec(32'h0A00_0000, 9'h101, "R5 bank3 unreachable");
        wr(12'h110, 32'hFFFF_FFFF);
        dec(32'h0A00_0000, 9'h108, "R5 restored");

        do_reset(1'b1);
        rd(12'h100, 32'h0, "R7 bank0 reset word swapped");
        dec(32'h3000_0000, 9'h102, "R6 catch-all goes to cs1");
        wr(12'h100, 32'h0000_0001);
        wr(12'h110, 32'hFFFF_FFFF);
        dec(32'h1000_0000, 9'h102, "R6 bank0 word drives cs1");
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h110, 32'h0000_8001);
        dec(32'h2000_0000, 9'h101, "R6 bank1 word drives cs0");
        dec(32'hFFFF_0000, 9'h102, "R6 parked bank0 on cs1");
        dec(32'h8000_0000, 9'h000, "R1 bank1 care bit31 miss");
        @(posedge clk); #1;
        strap = 1'b0;
        dec(32'h2000_0000, 9'h101, "R6 strap ignored after reset");

        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule